// File: doc/BRIEF.md
# Segmented Byte Histogram Unit

This block counts byte matches between two vector operands. Both operands are cut into 128-bit segments. For every byte of the N operand, the unit counts how many of the sixteen bytes of the M operand in the same segment hold the same value. That count goes into the result byte at the same position. No byte is ever compared with a byte from another segment. No predicate masks any lane.

An operation starts with a one-cycle `start` request, which carries the operands and an element-size code. It ends with a one-cycle `done` pulse. The result register holds its value until the next operation. Only the byte element size is legal. Any other size code ends the operation at once with an error flag. The vector width is a parameter and must be a whole number of segments. A second parameter chooses the variant. One variant computes every segment in the cycle of the request. The other keeps a single segment datapath and walks the segments one per cycle.

Each per-byte count uses no per-byte comparators. The broadcast key is XORed with each 64-bit half of the segment. A carry-free zero-byte test then marks every zero byte with its top bit. The mark mask of the upper half is shifted right by one bit and ORed onto the mask of the lower half. A single population count of that merged word gives the match count.

Top module: `seg_byte_hist`

## Requirements
- R1: `elem_size` code 2'b00 selects bytes and is the only legal code. An accepted request with any other code gives `done` and `size_err` high together in the next cycle, with `result` all zeros.
- R2: After a legal operation, result byte k of segment s equals the number of bytes j (0 to 15) of M segment s whose value equals byte k of N segment s.
- R3: Bytes of M outside a segment never add to the counts of that segment.
- R4: Each result byte is at most 16, and its bits 7 to 5 are zero. A count of 16 (0x10) is not saturated.
- R5: After the accepting clock edge of a legal request, `done` is high in the next cycle when PARALLEL=1. When PARALLEL=0 it is high NSEG cycles after that, where NSEG = VEC_BITS/128.
- R6: A request is accepted only when `busy` and `done` are both low. Requests at other times are ignored. In the serial variant, operand changes after acceptance do not affect the result.
- R7: `done` is a single-cycle pulse. `busy` and `done` are never high together. `size_err` is high only together with `done`.
- R8: While no operation is running and no request is made, `result` keeps its value.
- R9: `size_err` is low on the `done` pulse of a legal operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation request |
| elem_size | input | 2 | Element size code; 2'b00 = byte |
| vec_n | input | VEC_BITS | Key operand N |
| vec_m | input | VEC_BITS | Search operand M |
| busy | output | 1 | Serial walk in progress |
| done | output | 1 | Completion pulse |
| size_err | output | 1 | Illegal element size, valid with done |
| result | output | VEC_BITS | Per-byte match counts |

## Verification
Two cases are the hardest to reach with random bytes: a count of exactly 16, and a segment whose matches are all in the other segment. The stimulus creates them directly. One directed vector fills a segment with a single value. Another puts the key bytes of segment 0 only into M segment 1. The random vectors draw bytes from a four-value alphabet, so mid-range counts come up often. Both variants run side by side on the same operands. The serial variant also gets operand changes and a repeated request while it walks, to show that neither has any effect.

// File: rtl/shb_pkg.sv
package shb_pkg;
   localparam int SEG_BITS  = 128;
   localparam int SEG_BYTES = SEG_BITS / 8;
   localparam int HALF_BITS = SEG_BITS / 2;
   localparam int CNT_W     = $clog2(SEG_BYTES) + 1;

   typedef enum logic [1:0] {
      ESZ_BYTE = 2'b00,
      ESZ_HALF = 2'b01,
      ESZ_WORD = 2'b10,
      ESZ_DBL  = 2'b11
   } esz_e;

   function automatic logic [6:0] popcnt64(input logic [63:0] v);
      logic [6:0] acc;
      acc = '0;
      for (int i = 0; i < 64; i++) acc = acc + 7'(v[i]);
      return acc;
   endfunction
endpackage

// File: rtl/shb_zero_mask.sv
module shb_zero_mask #(
   parameter int W = 64
) (
   input  logic [7:0]   key,
   input  logic [W-1:0] word,
   output logic [W-1:0] zmask
);
   localparam int NB = W / 8;
   localparam logic [W-1:0] LOW7 = {NB{8'h7F}};

   if (W % 8 != 0) begin : g_bad_w
      $error("shb_zero_mask: W must be a multiple of 8");
   end

   logic [W-1:0] diff;
   logic [W-1:0] nz_sum;

   always_comb begin
      diff   = {NB{key}} ^ word;
      nz_sum = (diff & LOW7) + LOW7;
      zmask  = ~(nz_sum | diff | LOW7);
   end
endmodule

// File: rtl/shb_byte_counter.sv
module shb_byte_counter
   import shb_pkg::*;
(
   input  logic [7:0]          key,
   input  logic [SEG_BITS-1:0] seg_m,
   output logic [CNT_W-1:0]    count
);
   logic [HALF_BITS-1:0] mask_lo;
   logic [HALF_BITS-1:0] mask_hi;
   logic [HALF_BITS-1:0] merged;
   logic [6:0]           total;

   shb_zero_mask #(.W(HALF_BITS)) u_lo (
      .key(key), .word(seg_m[HALF_BITS-1:0]), .zmask(mask_lo));
   shb_zero_mask #(.W(HALF_BITS)) u_hi (
      .key(key), .word(seg_m[SEG_BITS-1:HALF_BITS]), .zmask(mask_hi));

   always_comb begin
      merged = mask_lo | (mask_hi >> 1);
      total  = popcnt64(merged);
      count  = total[CNT_W-1:0];
   end

   // R4: merged marks from both halves never exceed the segment size
   always_comb begin
      assert_count_range_R4: assert (total <= 7'(SEG_BYTES));
   end
endmodule

// File: rtl/shb_segment.sv
module shb_segment
   import shb_pkg::*;
(
   input  logic [SEG_BITS-1:0] seg_n,
   input  logic [SEG_BITS-1:0] seg_m,
   output logic [SEG_BITS-1:0] seg_res
);
   for (genvar k = 0; k < SEG_BYTES; k++) begin : g_lane
      logic [CNT_W-1:0] cnt;
      shb_byte_counter u_cnt (
         .key  (seg_n[k*8 +: 8]),
         .seg_m(seg_m),
         .count(cnt));
      assign seg_res[k*8 +: 8] = {{(8-CNT_W){1'b0}}, cnt};
   end
endmodule

// File: rtl/seg_byte_hist.sv
module seg_byte_hist
   import shb_pkg::*;
#(
   parameter int VEC_BITS = 256,
   parameter int PARALLEL = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [1:0]          elem_size,
   input  logic [VEC_BITS-1:0] vec_n,
   input  logic [VEC_BITS-1:0] vec_m,
   output logic                busy,
   output logic                done,
   output logic                size_err,
   output logic [VEC_BITS-1:0] result
);
   localparam int NSEG  = VEC_BITS / SEG_BITS;
   localparam int NBYTE = VEC_BITS / 8;
   localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1;

   if (VEC_BITS % SEG_BITS != 0 || VEC_BITS < SEG_BITS) begin : g_bad_len
      $error("seg_byte_hist: VEC_BITS must be a positive multiple of 128");
   end
   if (PARALLEL != 0 && PARALLEL != 1) begin : g_bad_mode
      $error("seg_byte_hist: PARALLEL must be 0 or 1");
   end

   logic accept;
   logic legal;
   assign accept = start && !busy && !done;
   assign legal  = (esz_e'(elem_size) == ESZ_BYTE);

   if (PARALLEL == 1) begin : g_par
      logic [VEC_BITS-1:0] all_res;
      for (genvar s = 0; s < NSEG; s++) begin : g_seg
         shb_segment u_seg (
            .seg_n  (vec_n[s*SEG_BITS +: SEG_BITS]),
            .seg_m  (vec_m[s*SEG_BITS +: SEG_BITS]),
            .seg_res(all_res[s*SEG_BITS +: SEG_BITS]));
      end

      assign busy = 1'b0;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            done     <= 1'b0;
            size_err <= 1'b0;
            result   <= '0;
         end else begin
            done     <= 1'b0;
            size_err <= 1'b0;
            if (accept) begin
               done     <= 1'b1;
               size_err <= !legal;
               result   <= legal ? all_res : '0;
            end
         end
      end
   end else begin : g_ser
      logic [VEC_BITS-1:0] n_q;
      logic [VEC_BITS-1:0] m_q;
      logic [IDX_W-1:0]    idx;
      logic                busy_q;
      logic [SEG_BITS-1:0] cur_n;
      logic [SEG_BITS-1:0] cur_m;
      logic [SEG_BITS-1:0] cur_res;

      assign cur_n = n_q[idx*SEG_BITS +: SEG_BITS];
      assign cur_m = m_q[idx*SEG_BITS +: SEG_BITS];
      assign busy  = busy_q;

      shb_segment u_seg (
         .seg_n  (cur_n),
         .seg_m  (cur_m),
         .seg_res(cur_res));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            n_q      <= '0;
            m_q      <= '0;
            idx      <= '0;
            busy_q   <= 1'b0;
            done     <= 1'b0;
            size_err <= 1'b0;
            result   <= '0;
         end else begin
            done     <= 1'b0;
            size_err <= 1'b0;
            if (accept) begin
               if (legal) begin
                  n_q    <= vec_n;
                  m_q    <= vec_m;
                  idx    <= '0;
                  busy_q <= 1'b1;
               end else begin
                  done     <= 1'b1;
                  size_err <= 1'b1;
                  result   <= '0;
               end
            end else if (busy_q) begin
               result[idx*SEG_BITS +: SEG_BITS] <= cur_res;
               if (idx == IDX_W'(NSEG - 1)) begin
                  busy_q <= 1'b0;
                  done   <= 1'b1;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
         end
      end
   end

   // R7: completion is a pulse, exclusive with busy, error only with done
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));
   assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      size_err |-> done);
   // R8: idle with no request keeps the result
   assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(result));
   // R1: illegal size returns a cleared result
   assert_err_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      size_err |-> (result == '0));

   // R4: upper three bits of every count byte are zero at completion
   for (genvar b = 0; b < NBYTE; b++) begin : g_chk
      assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
         done |-> (result[b*8+5 +: 3] == 3'b000));
   end
endmodule

// File: tb/seg_byte_hist_tb.sv
`timescale 1ns/1ps
module seg_byte_hist_tb;
   localparam int VB   = 256;
   localparam int NSEG = VB / 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          st_s = 1'b0;
   logic          st_p = 1'b0;
   logic [1:0]    esz = 2'b00;
   logic [VB-1:0] vn = '0;
   logic [VB-1:0] vm = '0;
   logic          busy_s, done_s, err_s, busy_p, done_p, err_p;
   logic [VB-1:0] res_s, res_p;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   seg_byte_hist #(.VEC_BITS(VB), .PARALLEL(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(st_s), .elem_size(esz),
      .vec_n(vn), .vec_m(vm), .busy(busy_s), .done(done_s),
      .size_err(err_s), .result(res_s));

   seg_byte_hist #(.VEC_BITS(VB), .PARALLEL(1)) u_dut_par (
      .clk(clk), .rst_n(rst_n), .start(st_p), .elem_size(esz),
      .vec_n(vn), .vec_m(vm), .busy(busy_p), .done(done_p),
      .size_err(err_p), .result(res_p));

   function automatic logic [VB-1:0] model(input logic [VB-1:0] n, input logic [VB-1:0] m);
      logic [VB-1:0] r;
      r = '0;
      for (int s = 0; s < NSEG; s++)
         for (int k = 0; k < 16; k++) begin
            logic [7:0] c;
            c = 8'd0;
            for (int j = 0; j < 16; j++)
               if (n[s*128 + k*8 +: 8] == m[s*128 + j*8 +: 8]) c = c + 8'd1;
            r[s*128 + k*8 +: 8] = c;
         end
      return r;
   endfunction

   function automatic logic [VB-1:0] rnd_vec(input int alpha_mask);
      logic [VB-1:0] v;
      for (int i = 0; i < VB/8; i++) v[i*8 +: 8] = 8'($urandom) & 8'(alpha_mask);
      return v;
   endfunction

   task automatic chk(input string req, input logic [VB-1:0] act, input logic [VB-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_op(input string tag, input logic [VB-1:0] n, input logic [VB-1:0] m,
                        input logic [1:0] sz);
      int lat_s, lat_p;
      logic [VB-1:0] rs, rp;
      logic es, ep;
      lat_s = 0; lat_p = 0; rs = '0; rp = '0; es = 1'b0; ep = 1'b0;
      @(negedge clk);
      vn = n; vm = m; esz = sz; st_s = 1'b1; st_p = 1'b1;
      @(negedge clk);
      st_s = 1'b0; st_p = 1'b0;
      for (int k = 1; k <= NSEG + 4; k++) begin
         if (done_s && lat_s == 0) begin lat_s = k; rs = res_s; es = err_s; end
         if (done_p && lat_p == 0) begin lat_p = k; rp = res_p; ep = err_p; end
         @(negedge clk);
      end
      if (sz == 2'b00) begin
         chk({"R2 R3 serial ", tag}, rs, model(n, m));
         chk({"R2 R3 parallel ", tag}, rp, model(n, m));
         chk("R5 serial latency", VB'(lat_s), VB'(NSEG + 1));
         chk("R5 parallel latency", VB'(lat_p), VB'(1));
         chk("R9 no error", VB'({es, ep}), VB'(0));
      end else begin
         chk({"R1 serial cleared ", tag}, rs, '0);
         chk({"R1 parallel cleared ", tag}, rp, '0);
         chk("R1 error flags", VB'({es, ep}), VB'(3));
         chk("R1 error latency", VB'({lat_s[7:0], lat_p[7:0]}), VB'({8'd1, 8'd1}));
      end
   endtask

   initial begin
      logic [VB-1:0] n1, m1, keep_s, keep_p, e;
      int seen;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("reset outputs", VB'({busy_s, done_s, err_s, busy_p, done_p, err_p}), VB'(0));
      chk("reset result", res_s | res_p, '0);

      // R4: all-equal segment gives 16 in each byte
      do_op("all equal", {VB/8{8'h3C}}, {VB/8{8'h3C}}, 2'b00);
      chk("R4 count 16", res_s, {VB/8{8'h10}});
      // no-match segments
      do_op("no match", {VB/8{8'h00}}, {VB/8{8'hFF}}, 2'b00);
      chk("R2 zero counts", res_p, '0);
      // R3: key values of seg0 only present in M seg1
      n1 = {{16{8'h11}}, {16{8'hAA}}};
      m1 = {{16{8'hAA}}, {16{8'h55}}};
      do_op("cross segment", n1, m1, 2'b00);
      chk("R3 isolation", res_s, '0);
      // distinct keys in one segment, mixed in other
      for (int i = 0; i < 16; i++) begin
         n1[i*8 +: 8] = 8'(i); m1[i*8 +: 8] = 8'(i % 4);
      end
      do_op("staircase", n1, m1, 2'b00);

      // R1: each illegal size
      for (int z = 1; z < 4; z++) do_op("illegal", rnd_vec(255), rnd_vec(255), 2'(z));

      // random mix
      for (int t = 0; t < 30; t++)
         do_op("random", rnd_vec((t % 3 == 0) ? 255 : 3), rnd_vec((t % 3 == 0) ? 255 : 3), 2'b00);

      // R8: idle operand changes keep result
      keep_s = res_s; keep_p = res_p;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); vn = rnd_vec(255); vm = rnd_vec(255);
      end
      @(negedge clk);
      chk("R8 serial hold", res_s, keep_s);
      chk("R8 parallel hold", res_p, keep_p);

      // R6 serial: request while busy ignored, operand change has no effect
      n1 = rnd_vec(3); m1 = rnd_vec(3); e = model(n1, m1);
      @(negedge clk); vn = n1; vm = m1; esz = 2'b00; st_s = 1'b1;
      @(negedge clk); vn = rnd_vec(255); vm = rnd_vec(255);
      @(negedge clk); st_s = 1'b0;
      seen = 0;
      for (int k = 0; k < NSEG + 6; k++) begin
         if (done_s) seen++;
         @(negedge clk);
      end
      chk("R6 serial capture", res_s, e);
      chk("R6 R7 single done", VB'(seen), VB'(1));

      // R6 parallel: request held while done is high is ignored
      n1 = rnd_vec(3); m1 = rnd_vec(3); e = model(n1, m1);
      @(negedge clk); vn = n1; vm = m1; st_p = 1'b1;
      @(negedge clk);
      chk("R7 parallel done", VB'(done_p), VB'(1));
      vn = rnd_vec(255); vm = rnd_vec(255);
      @(negedge clk); st_p = 1'b0;
      chk("R6 parallel ignored during done", VB'(done_p), VB'(0));
      chk("R6 parallel result", res_p, e);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule